// File: doc/BRIEF.md
# Nested interrupt priority controller

This block tracks the processor's current software interrupt priority and decides which pending interrupt, if any, may pre-empt the running code. The priority is a two-bit code. The four levels use a non-monotonic encoding, and the highest level means that maskable interrupts are blocked. Each maskable source has a programmable two-bit priority code. The block compares the decoded numeric level of each source with the current level and offers the processor the best eligible source.

The processor accepts the offered interrupt with a take strobe. The controller then saves the current code on a small nesting stack and loads the level of the accepted source. A return strobe pops the stack and restores the saved code. Two request lines, a top-level interrupt and a trap, bypass the mask and always win. Reset is the third source that bypasses the mask, and it is handled by the reset input. Software can overwrite the level code directly, which is how enable, disable, halt, wait and stack pop reach the block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: During synchronous active-low reset the current code becomes 11 (level 3) and every nesting stack entry becomes 11. Straight after reset no maskable source is offered.
- R2: Level codes decode as 10 = level 0, 01 = level 1, 00 = level 2 and 11 = level 3. A maskable source is eligible only when its request is high, its code is not 11, and its decoded level is strictly greater than the decoded current level.
- R3: Among eligible maskable sources, the highest decoded level wins. Ties go to the lowest source index. The offered vector equals that source index.
- R4: The top-level request (vector NUM_SRC) and the trap request (vector NUM_SRC+1) are offered at any current level, including level 3. The top-level request comes before the trap, and both come before any maskable source.
- R5: A take while a source is offered pushes the current code onto the stack. On the next cycle the current code equals the offered source's configured code, or 11 for the top-level or trap source.
- R6: A return strobe loads the top stack entry into the current code, and the stack pops in last-in first-out order. Each pop refills the bottom of the stack with 11, so a return on an empty stack yields 11.
- R7: A push onto a full stack of STACK_DEPTH entries discards the oldest entry. Later returns then restore the newer entries, followed by 11.
- R8: A software write loads sw_code on the next cycle. When several strobes arrive together, an effective take wins over a return, and a return wins over a software write.
- R9: A take strobe while nothing is offered changes neither the current code nor the stack. With no effective strobe the code holds.
- R10: irq_pending and irq_vec follow the request, priority and current-code inputs combinationally, in the same cycle. irq_vec is 0 when nothing is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Maskable request lines, bit i for source i |
| irq_prio | input | 2*NUM_SRC | Priority code of source i in bits [2i+1:2i] |
| tli_req | input | 1 | Top-level request, bypasses the mask |
| trap_req | input | 1 | Trap request, bypasses the mask |
| cpu_take | input | 1 | Processor accepts the offered interrupt |
| cpu_ret | input | 1 | Return-from-interrupt strobe |
| sw_wr | input | 1 | Software write of the level code |
| sw_code | input | 2 | Code written by software |
| irq_pending | output | 1 | A source is offered |
| irq_vec | output | $clog2(NUM_SRC+2) | Index of the offered source |
| cur_code | output | 2 | Current level code, {I1,I0} |

## Verification
The assertions assume that every request, priority and strobe input carries a known value on each clock edge. They also assume the processor samples irq_vec in the cycle in which it raises cpu_take. The strobes are not assumed to be exclusive: each property names the precedence case it covers. The bench changes inputs only between edges and draws every field from $urandom with legal two-bit values. It overlaps strobes on purpose so that the precedence order is exercised.

// File: rtl/nic_pkg.sv
// Package: shared types and level decoding for the nested interrupt controller.
// Assumes a two-bit code: 10 -> level 0, 01 -> 1, 00 -> 2, 11 -> 3 (masked).
package nic_pkg;

    typedef logic [1:0] code_t;
    typedef logic [1:0] lvl_t;

    localparam code_t CODE_MASKED = 2'b11;

    // Map a raw code to its numeric level.
    function automatic lvl_t code_to_lvl(input code_t c);
        return {~(c[1] ^ c[0]), c[0]};
    endfunction

endpackage

// File: rtl/nic_arbiter.sv
// Module: combinational arbiter. Picks the best eligible request against the
// current level. Non-maskable sources come first, then maskable ones by level,
// and ties go to the lowest index.
// Assumes irq_prio holds one two-bit code per source, source i at [2i+1:2i].
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic [2*NUM_SRC-1:0] irq_prio,
    input  logic                 tli_req,
    input  logic                 trap_req,
    input  code_t                cur_code,
    output logic                 pend,
    output logic [VEC_W-1:0]     vec,
    output code_t                new_code
);

    localparam logic [VEC_W-1:0] VEC_TLI  = VEC_W'(NUM_SRC);
    localparam logic [VEC_W-1:0] VEC_TRAP = VEC_W'(NUM_SRC + 1);

    lvl_t               cur_lvl;
    lvl_t               src_lvl [NUM_SRC];
    logic [NUM_SRC-1:0] src_ok;

    logic               best_hit;
    lvl_t               best_lvl;
    logic [VEC_W-1:0]   best_idx;
    code_t              best_code;

    assign cur_lvl = code_to_lvl(cur_code);

    // Per-source decode and eligibility test.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_lvl[g] = code_to_lvl(irq_prio[2*g +: 2]);
        assign src_ok[g]  = irq_req[g]
                          && (irq_prio[2*g +: 2] != CODE_MASKED)
                          && (src_lvl[g] > cur_lvl);
    end

    // Scan in ascending index order; replace only on a strictly higher level.
    always_comb begin
        best_hit  = 1'b0;
        best_lvl  = '0;
        best_idx  = '0;
        best_code = CODE_MASKED;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_ok[i] && (!best_hit || (src_lvl[i] > best_lvl))) begin
                best_hit  = 1'b1;
                best_lvl  = src_lvl[i];
                best_idx  = VEC_W'(i);
                best_code = irq_prio[2*i +: 2];
            end
        end
    end

    // Final selection: top-level, then trap, then the best maskable source.
    always_comb begin
        if (tli_req) begin
            pend     = 1'b1;
            vec      = VEC_TLI;
            new_code = CODE_MASKED;
        end else if (trap_req) begin
            pend     = 1'b1;
            vec      = VEC_TRAP;
            new_code = CODE_MASKED;
        end else begin
            pend     = best_hit;
            vec      = best_idx;
            new_code = best_code;
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
// Module: shift-register nesting stack of level codes. A push shifts toward
// the bottom and drops the oldest entry. A pop shifts toward the top and
// refills the bottom with the masked code.
// Assumes push and pop are never both high (the top resolves precedence).
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  code_t push_code,
    output code_t top_code
);

    code_t stk [DEPTH];

    assign top_code = stk[0];

    // Top entry: takes the pushed code, or the next entry on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk[0] <= CODE_MASKED;
        end else if (push) begin
            stk[0] <= push_code;
        end else if (pop) begin
            stk[0] <= (DEPTH > 1) ? stk[(DEPTH > 1) ? 1 : 0] : CODE_MASKED;
        end
    end

    // Remaining entries: shift down on push, up on pop.
    for (genvar g = 1; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stk[g] <= CODE_MASKED;
            end else if (push) begin
                stk[g] <= stk[g-1];
            end else if (pop) begin
                stk[g] <= (g == DEPTH-1) ? CODE_MASKED : stk[(g == DEPTH-1) ? g : g+1];
            end
        end
    end

endmodule

// File: rtl/nic_level_reg.sv
// Module: current priority code register (the I1/I0 pair).
// Precedence: effective take, then return, then software write.
// Assumes take_ok is already qualified with a pending request.
module nic_level_reg
    import nic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take_ok,
    input  logic  ret,
    input  logic  sw_wr,
    input  code_t new_code,
    input  code_t pop_code,
    input  code_t sw_code,
    output code_t cur_code
);

    // Hold or update the current code according to the strobe precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code <= CODE_MASKED;
        end else if (take_ok) begin
            cur_code <= new_code;
        end else if (ret) begin
            cur_code <= pop_code;
        end else if (sw_wr) begin
            cur_code <= sw_code;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: top of the nested interrupt priority controller. Ties together the
// arbiter, the current-code register and the nesting stack.
// Assumes the processor samples irq_vec in the same cycle it raises cpu_take.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter  int NUM_SRC     = 8,
    parameter  int STACK_DEPTH = 4,
    localparam int VEC_W       = $clog2(NUM_SRC + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic [2*NUM_SRC-1:0] irq_prio,
    input  logic                 tli_req,
    input  logic                 trap_req,
    input  logic                 cpu_take,
    input  logic                 cpu_ret,
    input  logic                 sw_wr,
    input  logic [1:0]           sw_code,
    output logic                 irq_pending,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [1:0]           cur_code
);

    code_t new_code;
    code_t stack_top;
    logic  take_ok;
    logic  pop_ok;

    // Strobe qualification: a take counts only when something is offered.
    assign take_ok = cpu_take & irq_pending;
    assign pop_ok  = cpu_ret & ~take_ok;

    nic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_arb (
        .irq_req  (irq_req),
        .irq_prio (irq_prio),
        .tli_req  (tli_req),
        .trap_req (trap_req),
        .cur_code (cur_code),
        .pend     (irq_pending),
        .vec      (irq_vec),
        .new_code (new_code)
    );

    nic_level_reg u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_ok  (take_ok),
        .ret      (cpu_ret),
        .sw_wr    (sw_wr),
        .new_code (new_code),
        .pop_code (stack_top),
        .sw_code  (sw_code),
        .cur_code (cur_code)
    );

    nic_level_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take_ok),
        .pop       (pop_ok),
        .push_code (cur_code),
        .top_code  (stack_top)
    );

endmodule

// File: rtl/nic_checker.sv
// Module: property checker for nest_irq_ctrl, attached with bind.
// Assumes known input values at every clock edge.
module nic_checker
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NUM_SRC-1:0] irq_prio,
    input logic                 tli_req,
    input logic                 trap_req,
    input logic                 cpu_take,
    input logic                 cpu_ret,
    input logic                 sw_wr,
    input logic [1:0]           sw_code,
    input logic                 irq_pending,
    input logic [VEC_W-1:0]     irq_vec,
    input logic [1:0]           cur_code,
    input logic [1:0]           stack_top
);

    logic eff_take;
    logic mask_vec;
    assign eff_take = cpu_take && irq_pending;
    assign mask_vec = int'(irq_vec) < NUM_SRC;

    p_reset_level_r1: assert property (@(posedge clk)
        !rst_n |=> cur_code == CODE_MASKED);

    p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && mask_vec) |->
            (irq_prio[2*int'(irq_vec) +: 2] != CODE_MASKED) &&
            (code_to_lvl(irq_prio[2*int'(irq_vec) +: 2]) > code_to_lvl(cur_code)));

    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == CODE_MASKED && !tli_req && !trap_req) |-> !irq_pending);

    p_tli_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tli_req |-> irq_pending && (int'(irq_vec) == NUM_SRC));

    p_trap_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !tli_req) |-> irq_pending && (int'(irq_vec) == NUM_SRC + 1));

    p_take_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_take && mask_vec) |=> cur_code == $past(irq_prio[2*int'(irq_vec) +: 2]));

    p_nmi_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_take && (tli_req || trap_req)) |=> cur_code == CODE_MASKED);

    p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eff_take |=> stack_top == $past(cur_code));

    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !eff_take) |=> cur_code == $past(stack_top));

    p_sw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !cpu_ret && !eff_take) |=> cur_code == $past(sw_code));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_take && !cpu_ret && !sw_wr) |=> $stable(cur_code));

endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
) u_nic_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_prio    (irq_prio),
    .tli_req     (tli_req),
    .trap_req    (trap_req),
    .cpu_take    (cpu_take),
    .cpu_ret     (cpu_ret),
    .sw_wr       (sw_wr),
    .sw_code     (sw_code),
    .irq_pending (irq_pending),
    .irq_vec     (irq_vec),
    .cur_code    (cur_code),
    .stack_top   (stack_top)
);

// File: tb/nest_irq_ctrl_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared with a
// reference model built from the requirements.
module nest_irq_ctrl_bench;

    localparam int NS    = 8;
    localparam int DEPTH = 4;
    localparam int VW    = $clog2(NS + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   irq_req = '0;
    logic [2*NS-1:0] irq_prio = '1;
    logic            tli_req = 1'b0, trap_req = 1'b0;
    logic            cpu_take = 1'b0, cpu_ret = 1'b0, sw_wr = 1'b0;
    logic [1:0]      sw_code = 2'b00;
    logic            irq_pending;
    logic [VW-1:0]   irq_vec;
    logic [1:0]      cur_code;

    int checks = 0;
    int failures = 0;

    logic [1:0] m_code;
    logic [1:0] m_stk [DEPTH];

    always #10 clk = ~clk;

    nest_irq_ctrl #(.NUM_SRC(NS), .STACK_DEPTH(DEPTH)) u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
        .tli_req(tli_req), .trap_req(trap_req), .cpu_take(cpu_take),
        .cpu_ret(cpu_ret), .sw_wr(sw_wr), .sw_code(sw_code),
        .irq_pending(irq_pending), .irq_vec(irq_vec), .cur_code(cur_code)
    );

    function automatic int lvl_of(input logic [1:0] c);
        case (c)
            2'b10:   return 0;
            2'b01:   return 1;
            2'b00:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [2*NS-1:0] put(input logic [2*NS-1:0] base,
                                            input int idx, input logic [1:0] c);
        logic [2*NS-1:0] r = base;
        r[2*idx +: 2] = c;
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check the combinational offer, update the model, check the code.
    task automatic step(input string tag, input logic [NS-1:0] rq, input logic [2*NS-1:0] pr,
                        input logic tl, input logic tp, input logic tk, input logic rt,
                        input logic sw, input logic [1:0] sc);
        bit ep = 0;
        int ev = 0;
        logic [1:0] enc = 2'b11;
        @(negedge clk);
        irq_req = rq; irq_prio = pr; tli_req = tl; trap_req = tp;
        cpu_take = tk; cpu_ret = rt; sw_wr = sw; sw_code = sc;
        #1;
        if (tl) begin
            ep = 1; ev = NS;
        end else if (tp) begin
            ep = 1; ev = NS + 1;
        end else begin
            for (int l = 3; l >= 0 && !ep; l--)
                for (int s = 0; s < NS && !ep; s++)
                    if (rq[s] && pr[2*s +: 2] != 2'b11 && lvl_of(pr[2*s +: 2]) == l
                        && l > lvl_of(m_code)) begin
                        ep = 1; ev = s; enc = pr[2*s +: 2];
                    end
        end
        chk(tag, "pending", int'(irq_pending), int'(ep));
        chk(tag, "vector", int'(irq_vec), ev);
        if (tk && ep) begin
            for (int i = DEPTH-1; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = m_code;
            m_code = enc;
        end else if (rt) begin
            m_code = m_stk[0];
            for (int i = 0; i < DEPTH-1; i++) m_stk[i] = m_stk[i+1];
            m_stk[DEPTH-1] = 2'b11;
        end else if (sw) begin
            m_code = sc;
        end
        @(posedge clk);
        #1;
        chk(tag, "cur_code", int'(cur_code), int'(m_code));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2*NS-1:0] p;
        m_code = 2'b11;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = 2'b11;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset code", int'(cur_code), 3);

        // R1/R2: level 3 blocks every maskable request.
        step("R1", '1, '0, 0, 0, 0, 0, 0, 2'b00);
        // R6: return on an empty stack yields 11.
        step("R6", '0, '1, 0, 0, 0, 1, 0, 2'b00);
        // R8: software drops to level 0.
        step("R8", '0, '1, 0, 0, 0, 0, 1, 2'b10);
        // R2: code 11 is never offered.
        step("R2", 8'h04, '1, 0, 0, 0, 0, 0, 2'b00);
        // R3: level 2 tie between sources 1 and 3 beats level 1 on source 5.
        p = put(put(put('1, 5, 2'b01), 3, 2'b00), 1, 2'b00);
        step("R3", 8'h2A, p, 0, 0, 1, 0, 0, 2'b00);
        // R2: an equal level is not eligible.
        step("R2", 8'h50, put(put('1, 4, 2'b00), 6, 2'b01), 0, 0, 0, 0, 0, 2'b00);
        // R4: top-level beats the trap; then the trap preempts level 3.
        step("R4", 8'h10, put('1, 4, 2'b00), 1, 1, 1, 0, 0, 2'b00);
        step("R4", 8'hFF, '0, 0, 1, 1, 0, 0, 2'b00);
        // R9: take with nothing offered.
        step("R9", '0, '1, 0, 0, 1, 0, 0, 2'b00);
        // R6: unwind in LIFO order.
        step("R6", '0, '1, 0, 0, 0, 1, 0, 2'b00);
        step("R6", '0, '1, 0, 0, 0, 1, 0, 2'b00);
        step("R6", '0, '1, 0, 0, 0, 1, 0, 2'b00);
        // R7: five nested takes on a four-deep stack, then five returns.
        step("R7", '0, '1, 0, 0, 0, 0, 1, 2'b10);
        step("R7", 8'h01, put('1, 0, 2'b01), 0, 0, 1, 0, 0, 2'b00);
        step("R7", 8'h02, put('1, 1, 2'b00), 0, 0, 1, 0, 0, 2'b00);
        step("R7", '0, '1, 1, 0, 1, 0, 0, 2'b00);
        step("R7", '0, '1, 0, 1, 1, 0, 0, 2'b00);
        step("R7", '0, '1, 0, 1, 1, 0, 0, 2'b00);
        for (int k = 0; k < 5; k++) step("R7", '0, '1, 0, 0, 0, 1, 0, 2'b00);
        // R8: precedence between overlapping strobes.
        step("R8", '0, '1, 0, 0, 0, 0, 1, 2'b10);
        step("R8", 8'h01, put('1, 0, 2'b00), 0, 0, 1, 1, 1, 2'b01);
        step("R8", '0, '1, 0, 0, 0, 1, 1, 2'b01);

        // R10 and the rest: seeded random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [2*NS-1:0] rp;
            int op;
            string tg;
            for (int s = 0; s < NS; s++) rp[2*s +: 2] = 2'($urandom);
            op = int'($urandom % 8);
            tg = (op < 3) ? "R5" : (op < 5) ? "R6" : (op < 7) ? "R8" : "R10";
            step(tg, NS'($urandom), rp, ($urandom % 24) == 0, ($urandom % 20) == 0,
                 op < 3 || op == 6, op == 3 || op == 4, op == 5 || op == 6, 2'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule